// File: doc/BRIEF.md
# ARP request responder

This block sits on the receive and transmit byte streams of an Ethernet port and answers address-resolution requests for the local station. Frames arrive one byte per beat with valid and last qualifiers, and every beat is consumed. The block checks the frame-type and fixed protocol fields as they arrive. It keeps the requester's hardware and network addresses and compares the queried network address with the local one.

When a complete, well-formed request names the local address, the block drives a reply frame of `FRAME_LEN` bytes on the transmit stream, starting in the next clock cycle. Nothing is buffered: the reply is generated byte by byte from the captured addresses and the static local address inputs. The block also keeps a wrapping count of the requests it has answered.

Top module: `arp_responder`

## Requirements
- R1: After reset, tx_valid and tx_last are low, arp_count is 0, and rx_ready is high and stays high.
- R2: A frame qualifies only if bytes 12..21 (counting from 0) are 08 06 00 01 08 00 06 04 00 01. These are the frame type, hardware type, protocol type, the two address sizes and the request opcode. Any other value in these bytes gives no reply and leaves arp_count unchanged, which includes IPv4 frames (type 08 00). Bytes 0..11 and 32..37 are not checked.
- R3: A frame qualifies only if bytes 38..41 equal local_ip, most significant byte first.
- R4: On a qualifying frame, tx_valid rises in the cycle after the beat with rx_last. tx_valid falls in the cycle after the final byte is accepted.
- R5: The reply is FRAME_LEN bytes (60 by default). Its layout, from byte 0, is:
  - bytes 0..5: requester MAC (request bytes 22..27)
  - bytes 6..11: local_mac
  - bytes 12..21: 08 06 00 01 08 00 06 04 00 02
  - bytes 22..27: local_mac
  - bytes 28..31: local_ip
  - bytes 32..37: requester MAC
  - bytes 38..41: requester IP (request bytes 28..31)
  - the remaining bytes: zero
  
  Addresses go out most significant byte first. tx_last is high only on the final byte.
- R6: Bytes after byte 41 and before rx_last are pad and are ignored, whatever their value. A frame whose rx_last falls before byte 41 does not qualify.
- R7: A transmit byte advances only on a cycle with tx_valid and tx_ready both high. While tx_ready is low, tx_data and tx_valid hold.
- R8: arp_count increments by one for each request that is answered, and wraps from 255 to 0.
- R9: A request that has any beat while a reply is in progress is dropped. It is not counted, it gets no reply of its own, and the reply in progress is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| local_mac | input | 48 | Station hardware address, static |
| local_ip | input | 32 | Station network address, static |
| rx_data | input | 8 | Receive byte |
| rx_valid | input | 1 | Receive byte valid |
| rx_last | input | 1 | Final byte of the receive frame |
| rx_ready | output | 1 | Always high; every beat is consumed |
| tx_data | output | 8 | Reply byte |
| tx_valid | output | 1 | Reply byte valid |
| tx_last | output | 1 | Final reply byte |
| tx_ready | input | 1 | Downstream accepts the reply byte |
| arp_count | output | CNT_W | Answered request count, wrapping |

## Verification
The hardest case to reach is a second request arriving while a reply is still on the wire. The captured requester addresses feed the reply directly, so such a request would corrupt the output if it were not blocked. The stimulus holds tx_ready low after a first request, pushes a complete second request with different addresses, and then drains the reply. The reply must still carry the first requester, and the count must have moved by one. The counter wrap is reached by answering enough requests to pass 255.

// File: rtl/arp_responder.sv
module arp_responder #(
  parameter int FRAME_LEN = 60,
  parameter int CNT_W     = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [47:0]      local_mac,
  input  logic [31:0]      local_ip,
  input  logic [7:0]       rx_data,
  input  logic             rx_valid,
  input  logic             rx_last,
  output logic             rx_ready,
  output logic [7:0]       tx_data,
  output logic             tx_valid,
  output logic             tx_last,
  input  logic             tx_ready,
  output logic [CNT_W-1:0] arp_count
);
  localparam int IW = 6;
  localparam logic [IW-1:0] LAST_IDX = IW'(FRAME_LEN - 1);

  function automatic logic [7:0] mac_at(logic [47:0] m, logic [IW-1:0] k);
    return 8'(m >> (9'd40 - {k, 3'b000}));
  endfunction

  function automatic logic [7:0] ip_at(logic [31:0] a, logic [IW-1:0] k);
    return 8'(a >> (9'd24 - {k, 3'b000}));
  endfunction

  function automatic logic [7:0] hdr_at(logic [IW-1:0] k, logic reply);
    case (k)
      6'd12: return 8'h08;
      6'd13: return 8'h06;
      6'd15: return 8'h01;
      6'd16: return 8'h08;
      6'd18: return 8'h06;
      6'd19: return 8'h04;
      6'd21: return reply ? 8'h02 : 8'h01;
      default: return 8'h00;
    endcase
  endfunction

  logic [IW-1:0] rx_idx, tx_idx;
  logic          rx_ok, busy, byte_ok, accept;
  logic [47:0]   peer_mac;
  logic [31:0]   peer_ip;

  assign rx_ready = 1'b1;

  always_comb begin
    byte_ok = 1'b1;
    if (rx_idx >= 6'd12 && rx_idx <= 6'd21) byte_ok = (rx_data == hdr_at(rx_idx, 1'b0));
    else if (rx_idx >= 6'd38 && rx_idx <= 6'd41) byte_ok = (rx_data == ip_at(local_ip, rx_idx - 6'd38));
  end

  assign accept = rx_valid && rx_last && rx_ok && byte_ok && !busy && rx_idx >= 6'd41;

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_idx <= '0;
      rx_ok  <= 1'b1;
    end else if (rx_valid) begin
      if (rx_last) begin
        rx_idx <= '0;
        rx_ok  <= 1'b1;
      end else begin
        if (rx_idx != 6'd63) rx_idx <= rx_idx + 6'd1;
        rx_ok <= rx_ok && byte_ok && !busy;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      peer_mac <= '0;
      peer_ip  <= '0;
    end else if (rx_valid && !busy) begin
      if (rx_idx >= 6'd22 && rx_idx <= 6'd27) peer_mac <= {peer_mac[39:0], rx_data};
      if (rx_idx >= 6'd28 && rx_idx <= 6'd31) peer_ip  <= {peer_ip[23:0], rx_data};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      tx_idx    <= '0;
      arp_count <= '0;
    end else if (accept) begin
      busy      <= 1'b1;
      tx_idx    <= '0;
      arp_count <= arp_count + 1'b1;
    end else if (busy && tx_ready) begin
      if (tx_idx == LAST_IDX) busy <= 1'b0;
      else tx_idx <= tx_idx + 6'd1;
    end
  end

  always_comb begin
    if (tx_idx < 6'd6)        tx_data = mac_at(peer_mac, tx_idx);
    else if (tx_idx < 6'd12)  tx_data = mac_at(local_mac, tx_idx - 6'd6);
    else if (tx_idx < 6'd22)  tx_data = hdr_at(tx_idx, 1'b1);
    else if (tx_idx < 6'd28)  tx_data = mac_at(local_mac, tx_idx - 6'd22);
    else if (tx_idx < 6'd32)  tx_data = ip_at(local_ip, tx_idx - 6'd28);
    else if (tx_idx < 6'd38)  tx_data = mac_at(peer_mac, tx_idx - 6'd32);
    else if (tx_idx < 6'd42)  tx_data = ip_at(peer_ip, tx_idx - 6'd38);
    else                      tx_data = 8'h00;
  end

  assign tx_valid = busy;
  assign tx_last  = busy && tx_idx == LAST_IDX;

  a_r5_last_in_frame: assert property (@(posedge clk) disable iff (rst) tx_last |-> tx_valid);
  a_r7_hold_on_stall: assert property (@(posedge clk) disable iff (rst)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data));
  a_r4_start_after_last: assert property (@(posedge clk) disable iff (rst)
    $rose(tx_valid) |-> $past(rx_valid && rx_last));
  a_r4_end_after_final: assert property (@(posedge clk) disable iff (rst)
    tx_last && tx_ready |=> !tx_valid);
  a_r8_step_one: assert property (@(posedge clk) disable iff (rst)
    arp_count != $past(arp_count) |-> arp_count == CNT_W'($past(arp_count) + 1'b1));
endmodule

// File: tb/arp_responder_bench.sv
module arp_responder_bench;
  logic clk = 0, rst = 1;
  logic [47:0] local_mac = 48'h02_11_22_33_44_55;
  logic [31:0] local_ip  = 32'hC0_A8_05_09;
  logic [7:0] rx_data = 0;
  logic rx_valid = 0, rx_last = 0, tx_ready = 0;
  logic rx_ready, tx_valid, tx_last;
  logic [7:0] tx_data, arp_count;

  arp_responder u_arp_responder (.clk, .rst, .local_mac, .local_ip, .rx_data, .rx_valid,
    .rx_last, .rx_ready, .tx_data, .tx_valid, .tx_last, .tx_ready, .arp_count);

  always #2.5 clk = ~clk;

  int checks = 0, errors = 0;
  int model_cnt = 0;
  logic [7:0] fr [64];

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] nth(input logic [63:0] v, input int w, input int k);
    return 8'(v >> (8 * (w - 1 - k)));
  endfunction

  task automatic build(input logic [47:0] pm, input logic [31:0] pip);
    logic [7:0] hdr [10] = '{8'h08, 8'h06, 8'h00, 8'h01, 8'h08, 8'h00, 8'h06, 8'h04, 8'h00, 8'h01};
    for (int i = 0; i < 64; i++) fr[i] = 8'(8'hA0 + i);
    for (int i = 0; i < 6; i++) begin fr[i] = 8'hFF; fr[22+i] = nth(pm, 6, i); fr[32+i] = 8'h00; end
    for (int i = 0; i < 10; i++) fr[12+i] = hdr[i];
    for (int i = 0; i < 4; i++) begin fr[28+i] = nth(pip, 4, i); fr[38+i] = nth(local_ip, 4, i); end
  endtask

  function automatic logic [7:0] reply_at(input int k, input logic [47:0] pm, input logic [31:0] pip);
    logic [7:0] hdr [10] = '{8'h08, 8'h06, 8'h00, 8'h01, 8'h08, 8'h00, 8'h06, 8'h04, 8'h00, 8'h02};
    if (k < 6) return nth(pm, 6, k);
    if (k < 12) return nth(local_mac, 6, k - 6);
    if (k < 22) return hdr[k - 12];
    if (k < 28) return nth(local_mac, 6, k - 22);
    if (k < 32) return nth(local_ip, 4, k - 28);
    if (k < 38) return nth(pm, 6, k - 32);
    if (k < 42) return nth(pip, 4, k - 38);
    return 8'h00;
  endfunction

  task automatic send(input int len);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      rx_valid = 1; rx_data = fr[i]; rx_last = (i == len - 1);
    end
    @(negedge clk);
    rx_valid = 0; rx_last = 0; rx_data = 0;
  endtask

  task automatic drain(input logic [47:0] pm, input logic [31:0] pip, input bit stall, input string tag);
    int j = 0, bad = 0, g = 0;
    while (j < 60 && g < 400) begin
      tx_ready = stall ? (g % 3 != 1) : 1'b1;
      if (tx_valid && tx_ready) begin
        if (tx_data !== reply_at(j, pm, pip) || tx_last !== (j == 59)) begin
          bad++;
          $display("FAIL %s byte %0d actual=%0h expected=%0h", tag, j, tx_data, reply_at(j, pm, pip));
        end
        j++;
      end
      g++;
      @(negedge clk);
    end
    tx_ready = 0;
    chk(bad == 0 && j == 60, tag, j, 60);
    chk(tx_valid == 0, {tag, " R4 valid falls"}, tx_valid, 0);
  endtask

  localparam int NV = 14;
  localparam logic [24:0] VEC [NV] = '{
    {8'd60, 8'hFF, 8'h00, 1'b1},
    {8'd60, 8'd13, 8'h00, 1'b0},
    {8'd60, 8'd12, 8'h86, 1'b0},
    {8'd60, 8'd15, 8'h06, 1'b0},
    {8'd60, 8'd17, 8'h06, 1'b0},
    {8'd60, 8'd18, 8'h05, 1'b0},
    {8'd60, 8'd19, 8'h10, 1'b0},
    {8'd60, 8'd21, 8'h02, 1'b0},
    {8'd60, 8'd41, 8'h0A, 1'b0},
    {8'd60, 8'd38, 8'hC1, 1'b0},
    {8'd60, 8'd35, 8'h77, 1'b1},
    {8'd41, 8'hFF, 8'h00, 1'b0},
    {8'd42, 8'hFF, 8'h00, 1'b1},
    {8'd64, 8'd50, 8'h5A, 1'b1}
  };

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [47:0] pm;
    logic [31:0] pip;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(tx_valid == 0 && tx_last == 0, "R1 tx idle", {tx_valid, tx_last}, 0);
    chk(arp_count == 0, "R1 count", arp_count, 0);
    chk(rx_ready == 1, "R1 rx_ready", rx_ready, 1);

    for (int v = 0; v < NV; v++) begin
      pm = 48'h0A_1B_2C_3D_4E_00 | 48'(v);
      pip = 32'hC0_A8_05_01 + 32'(v);
      build(pm, pip);
      if (VEC[v][16:9] != 8'hFF) fr[VEC[v][16:9]] = VEC[v][8:1];
      send(int'(VEC[v][24:17]));
      chk(tx_valid == VEC[v][0], $sformatf("R2 R3 R6 vec %0d reply start (R4)", v), tx_valid, VEC[v][0]);
      if (VEC[v][0]) begin
        model_cnt++;
        drain(pm, pip, 0, $sformatf("R5 vec %0d", v));
      end else begin
        repeat (5) @(negedge clk);
        chk(tx_valid == 0, $sformatf("R2 vec %0d no reply", v), tx_valid, 0);
      end
      chk(arp_count == 8'(model_cnt), $sformatf("R8 vec %0d count", v), arp_count, model_cnt);
    end

    pm = 48'h0C_0D_0E_0F_10_11; pip = 32'h0A_00_00_07;
    build(pm, pip);
    send(60);
    model_cnt++;
    drain(pm, pip, 1, "R7 stalled reply");

    pm = 48'h22_33_44_55_66_77; pip = 32'h0A_00_00_08;
    build(pm, pip);
    send(60);
    model_cnt++;
    build(48'h99_88_77_66_55_44, 32'h0A_00_00_63);
    send(60);
    chk(arp_count == 8'(model_cnt), "R9 overlap not counted", arp_count, model_cnt);
    drain(pm, pip, 0, "R9 reply unchanged");
    repeat (4) @(negedge clk);
    chk(tx_valid == 0, "R9 no second reply", tx_valid, 0);

    build(48'h01_02_03_04_05_06, 32'h0A_00_00_09);
    while (model_cnt < 257) begin
      send(42);
      model_cnt++;
      tx_ready = 1;
      while (tx_valid) @(negedge clk);
      tx_ready = 0;
    end
    chk(arp_count == 8'd1, "R8 wrap", arp_count, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule